// File: doc/BRIEF.md
# Masked Interrupt Controller with Software Source

This block gathers level-sensitive interrupt requests from up to 32 normal sources and one fast source. It gates each request through a per-source enable bit, then drives one normal interrupt line and one fast interrupt line toward the processor. Software reaches it through a small register-mapped slave port with select, enable, write, address and data signals. Through that port it reads the raw and the gated status, reads the enable mask, and changes single enable bits with write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed.

One of the normal sources has no pin. It is a sticky flag held inside the block, which software sets and clears through a register. A fast-interrupt handler uses it to hand work to the normal interrupt path. The hardware inputs are not latched, so their status follows the input levels in every cycle.

Top module: `intr_mask_ctrl`

## Requirements
- R1: After reset every enable bit and the software flag are 0, so `irqOut` and `fiqOut` are low and reads of offsets 0x04, 0x08, 0x14 and 0x24 return 0, whatever the input levels are.
- R2: A read of offset 0x00 returns the current `irqSrc` levels in the same cycle. Bit 1 is the exception: it shows the software flag. Nothing is latched.
- R3: A write to offset 0x0C sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value. The change is visible from the cycle after the write's access edge.
- R4: A write to offset 0x10 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R5: A read of offset 0x08 returns the enable mask. A read of offset 0x04 returns the raw status ANDed with the mask.
- R6: `irqOut` is high exactly when at least one bit of the gated status is 1, with no added cycle of delay.
- R7: A write to offset 0x14 loads data bit 0 into the software flag (1 raises it, 0 drops it). The flag holds until it is written again. Bit 0 of a read of 0x14 returns the flag. The level on the `irqSrc[1]` pin has no effect anywhere.
- R8: The fast source has its own registers: raw level at 0x20 bit 0, gated level at 0x24 bit 0, enable-set at 0x28 (data bit 0), and enable-clear at 0x2C (data bit 0). `fiqOut` equals `fiqSrc` ANDed with its enable.
- R9: A register changes only when `pSel`, `pEnable` and `pWrite` are all high at a clock edge. A setup phase alone changes nothing. Reads of 0x0C, 0x10, 0x28 and 0x2C, and of any unmapped offset, return 0.

Registers not called out above read as 0 in every unused bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pSel | input | 1 | Slave select |
| pEnable | input | 1 | Access-phase strobe |
| pWrite | input | 1 | 1 = write, 0 = read |
| pAddr | input | ADDR_W (8) | Byte offset from the block base |
| pWdata | input | DATA_W (32) | Write data |
| pRdata | output | DATA_W (32) | Read data, combinational from the address |
| irqSrc | input | NUM_SRC (32) | Level-sensitive normal interrupt requests |
| fiqSrc | input | 1 | Level-sensitive fast interrupt request |
| irqOut | output | 1 | Normal interrupt to the processor |
| fiqOut | output | 1 | Fast interrupt to the processor |

## Verification
Read data, the two interrupt outputs and the raw status are combinational. They are due in the same cycle as the address or input change that causes them. The enable bits and the software flag change at the clock edge that ends a write's access phase, so they are due in the cycle after that edge. The bench drives every input on the falling edge and samples one nanosecond later. A write therefore has always passed its committing rising edge before its result is read, and an input change is always read back before the next rising edge.

// File: rtl/intr_pkg.sv
package intr_pkg;

  localparam logic [7:0] OFS_IRQ_RAW  = 8'h00;
  localparam logic [7:0] OFS_IRQ_MSK  = 8'h04;
  localparam logic [7:0] OFS_IRQ_EN   = 8'h08;
  localparam logic [7:0] OFS_IRQ_SET  = 8'h0C;
  localparam logic [7:0] OFS_IRQ_CLR  = 8'h10;
  localparam logic [7:0] OFS_SOFT     = 8'h14;
  localparam logic [7:0] OFS_FIQ_RAW  = 8'h20;
  localparam logic [7:0] OFS_FIQ_MSK  = 8'h24;
  localparam logic [7:0] OFS_FIQ_SET  = 8'h28;
  localparam logic [7:0] OFS_FIQ_CLR  = 8'h2C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_IRQ_RAW,
    RD_IRQ_MSK,
    RD_IRQ_EN,
    RD_SOFT,
    RD_FIQ_RAW,
    RD_FIQ_MSK
  } rdSel_e;

  typedef struct packed {
    logic   irqSet;
    logic   irqClr;
    logic   softWr;
    logic   fiqSet;
    logic   fiqClr;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/intr_ctrl_dec.sv
module intr_ctrl_dec
  import intr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  output ctrlStrobe_t       strobe
);

  logic wrAccess;
  logic rdAccess;

  assign wrAccess = pSel & pEnable & pWrite;
  assign rdAccess = pSel & ~pWrite;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (wrAccess) begin
      case (pAddr)
        ADDR_W'(OFS_IRQ_SET): strobe.irqSet = 1'b1;
        ADDR_W'(OFS_IRQ_CLR): strobe.irqClr = 1'b1;
        ADDR_W'(OFS_SOFT):    strobe.softWr = 1'b1;
        ADDR_W'(OFS_FIQ_SET): strobe.fiqSet = 1'b1;
        ADDR_W'(OFS_FIQ_CLR): strobe.fiqClr = 1'b1;
        default: ;
      endcase
    end
    if (rdAccess) begin
      case (pAddr)
        ADDR_W'(OFS_IRQ_RAW): strobe.rdSel = RD_IRQ_RAW;
        ADDR_W'(OFS_IRQ_MSK): strobe.rdSel = RD_IRQ_MSK;
        ADDR_W'(OFS_IRQ_EN):  strobe.rdSel = RD_IRQ_EN;
        ADDR_W'(OFS_SOFT):    strobe.rdSel = RD_SOFT;
        ADDR_W'(OFS_FIQ_RAW): strobe.rdSel = RD_FIQ_RAW;
        ADDR_W'(OFS_FIQ_MSK): strobe.rdSel = RD_FIQ_MSK;
        default:              strobe.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SOFT_BIT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  pWdata,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic               fiqSrc,
  output logic [DATA_W-1:0]  pRdata,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_SRC-1:0] irqMask
);

  logic [NUM_SRC-1:0] irqRaw;
  logic [NUM_SRC-1:0] irqGated;
  logic [NUM_SRC-1:0] irqMaskNxt;
  logic [NUM_SRC-1:0] wrBits;
  logic               softReq;
  logic               fiqMask;
  logic               fiqGated;
  logic               unusedSoftPin;

  assign wrBits        = pWdata[NUM_SRC-1:0];
  assign unusedSoftPin = irqSrc[SOFT_BIT];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_raw
    if (i == SOFT_BIT) begin : g_soft
      assign irqRaw[i] = softReq;
    end else begin : g_pin
      assign irqRaw[i] = irqSrc[i];
    end
  end

  always_comb begin
    irqMaskNxt = irqMask;
    if (strobe.irqSet)      irqMaskNxt = irqMask | wrBits;
    else if (strobe.irqClr) irqMaskNxt = irqMask & ~wrBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqMask <= '0;
      softReq <= 1'b0;
      fiqMask <= 1'b0;
    end else begin
      irqMask <= irqMaskNxt;
      if (strobe.softWr) softReq <= pWdata[0];
      if (strobe.fiqSet && pWdata[0])      fiqMask <= 1'b1;
      else if (strobe.fiqClr && pWdata[0]) fiqMask <= 1'b0;
    end
  end

  assign irqGated = irqRaw & irqMask;
  assign fiqGated = fiqSrc & fiqMask;
  assign irqOut   = |irqGated;
  assign fiqOut   = fiqGated;

  always_comb begin
    case (strobe.rdSel)
      RD_IRQ_RAW: pRdata = DATA_W'(irqRaw);
      RD_IRQ_MSK: pRdata = DATA_W'(irqGated);
      RD_IRQ_EN:  pRdata = DATA_W'(irqMask);
      RD_SOFT:    pRdata = DATA_W'(softReq);
      RD_FIQ_RAW: pRdata = DATA_W'(fiqSrc);
      RD_FIQ_MSK: pRdata = DATA_W'(fiqGated);
      default:    pRdata = '0;
    endcase
  end

endmodule

// File: rtl/intr_mask_ctrl.sv
module intr_mask_ctrl
  import intr_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SOFT_BIT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pSel,
  input  logic               pEnable,
  input  logic               pWrite,
  input  logic [ADDR_W-1:0]  pAddr,
  input  logic [DATA_W-1:0]  pWdata,
  output logic [DATA_W-1:0]  pRdata,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic               fiqSrc,
  output logic               irqOut,
  output logic               fiqOut
);

  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] irqMask;

  intr_ctrl_dec #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .pSel    (pSel),
    .pEnable (pEnable),
    .pWrite  (pWrite),
    .pAddr   (pAddr),
    .strobe  (strobe)
  );

  intr_datapath #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .SOFT_BIT (SOFT_BIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pWdata  (pWdata),
    .irqSrc  (irqSrc),
    .fiqSrc  (fiqSrc),
    .pRdata  (pRdata),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut),
    .irqMask (irqMask)
  );

endmodule

// File: rtl/intr_mask_ctrl_chk.sv
module intr_mask_ctrl_chk
  import intr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               pSel,
  input logic               pEnable,
  input logic               pWrite,
  input logic [ADDR_W-1:0]  pAddr,
  input logic [DATA_W-1:0]  pWdata,
  input logic [DATA_W-1:0]  pRdata,
  input logic               fiqSrc,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] irqMask
);

  logic               wrAcc;
  logic               wrSet;
  logic               wrClr;
  logic               rdGated;
  logic [NUM_SRC-1:0] wdLow;

  assign wrAcc   = pSel && pEnable && pWrite;
  assign wrSet   = wrAcc && (pAddr == ADDR_W'(OFS_IRQ_SET));
  assign wrClr   = wrAcc && (pAddr == ADDR_W'(OFS_IRQ_CLR));
  assign rdGated = pSel && !pWrite && (pAddr == ADDR_W'(OFS_IRQ_MSK));
  assign wdLow   = pWdata[NUM_SRC-1:0];

  AST_MASK_SET_ONES: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> ((irqMask & $past(wdLow)) == $past(wdLow))); // R3
  AST_MASK_SET_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> ((irqMask & $past(irqMask)) == $past(irqMask))); // R3
  AST_MASK_CLR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((irqMask & $past(wdLow)) == '0)); // R4
  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrSet || wrClr) |=> $stable(irqMask)); // R9
  AST_GATED_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    rdGated |-> ((pRdata[NUM_SRC-1:0] & ~irqMask) == '0)); // R5
  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rstN)
    rdGated |-> (irqOut == (|pRdata))); // R6
  AST_FIQ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> fiqSrc); // R8

endmodule

bind intr_mask_ctrl intr_mask_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pSel    (pSel),
  .pEnable (pEnable),
  .pWrite  (pWrite),
  .pAddr   (pAddr),
  .pWdata  (pWdata),
  .pRdata  (pRdata),
  .fiqSrc  (fiqSrc),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .irqMask (irqMask)
);

// File: tb/intr_mask_ctrl_tb.sv
`timescale 1ns/1ps
module intr_mask_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0;
  logic        pEnable = 1'b0;
  logic        pWrite = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic [31:0] irqSrc = '0;
  logic        fiqSrc = 1'b0;
  logic        irqOut;
  logic        fiqOut;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mdlMask = '0;
  logic        mdlSoft = 1'b0;
  logic        mdlFiqEn = 1'b0;

  always #2.5 clk = ~clk;

  intr_mask_ctrl u_dut (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .irqSrc(irqSrc),
    .fiqSrc(fiqSrc), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic logic [31:0] expRaw();
    return (irqSrc & ~32'h2) | {30'd0, mdlSoft, 1'b0};
  endfunction

  function automatic logic [31:0] expGated();
    return expRaw() & mdlMask;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b1; pEnable = 1'b0; pAddr = a; pWdata = d;
    @(negedge clk);
    pEnable = 1'b1;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
  endtask

  task automatic apbRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b0; pEnable = 1'b0; pAddr = a;
    @(negedge clk);
    pEnable = 1'b1;
    #1 d = pRdata;
    pSel = 1'b0; pEnable = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] d;
    apbRead(8'h00, d); check({"R2 raw ", tag}, d, expRaw());
    apbRead(8'h04, d); check({"R5 gated ", tag}, d, expGated());
    check({"R6 irqOut ", tag}, {31'd0, irqOut}, {31'd0, |expGated()});
    apbRead(8'h08, d); check({"R5 mask ", tag}, d, mdlMask);
    apbRead(8'h14, d); check({"R7 soft ", tag}, d, {31'd0, mdlSoft});
    apbRead(8'h20, d); check({"R8 fiq raw ", tag}, d, {31'd0, fiqSrc});
    apbRead(8'h24, d); check({"R8 fiq gated ", tag}, d, {31'd0, fiqSrc & mdlFiqEn});
    check({"R8 fiqOut ", tag}, {31'd0, fiqOut}, {31'd0, fiqSrc & mdlFiqEn});
  endtask

  initial begin
    #(5.0 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240607));
    irqSrc = 32'hFFFF_FFFF;
    fiqSrc = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state with every input high
    #1;
    check("R1 irqOut after reset", {31'd0, irqOut}, 32'd0);
    check("R1 fiqOut after reset", {31'd0, fiqOut}, 32'd0);
    apbRead(8'h04, d); check("R1 gated", d, 32'd0);
    apbRead(8'h08, d); check("R1 mask", d, 32'd0);
    apbRead(8'h14, d); check("R1 soft", d, 32'd0);
    apbRead(8'h24, d); check("R1 fiq gated", d, 32'd0);
    checkAll("post-reset");

    // R9: setup phase only, held across two edges
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b1; pEnable = 1'b0; pAddr = 8'h0C; pWdata = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    pSel = 1'b0; pWrite = 1'b0;
    apbRead(8'h08, d); check("R9 setup-only leaves mask", d, 32'd0);

    // R9: write-only and unmapped offsets read zero
    apbWrite(8'h28, 32'h1); mdlFiqEn = 1'b1;
    apbWrite(8'h0C, 32'hA5A5_0F0F); mdlMask = 32'hA5A5_0F0F;
    apbRead(8'h0C, d); check("R9 read set reg", d, 32'd0);
    apbRead(8'h10, d); check("R9 read clr reg", d, 32'd0);
    apbRead(8'h28, d); check("R9 read fiq set reg", d, 32'd0);
    apbRead(8'h2C, d); check("R9 read fiq clr reg", d, 32'd0);
    apbRead(8'h3C, d); check("R9 read unmapped", d, 32'd0);

    // R3/R4: zeros leave bits alone
    apbWrite(8'h0C, 32'h0000_00F0); mdlMask |= 32'h0000_00F0;
    checkAll("R3 partial set");
    apbWrite(8'h10, 32'h0000_0F00); mdlMask &= ~32'h0000_0F00;
    checkAll("R4 partial clear");

    // R7: pin 1 ignored, flag sticky
    apbWrite(8'h0C, 32'hFFFF_FFFF); mdlMask = 32'hFFFF_FFFF;
    @(negedge clk); irqSrc = 32'h0000_0002; fiqSrc = 1'b0;
    #1 check("R7 pin1 ignored irqOut", {31'd0, irqOut}, 32'd0);
    apbRead(8'h00, d); check("R7 pin1 ignored raw", d, 32'd0);
    apbWrite(8'h14, 32'h1); mdlSoft = 1'b1;
    @(negedge clk); irqSrc = 32'd0;
    #1 check("R7 soft drives irqOut", {31'd0, irqOut}, 32'd1);
    repeat (4) @(negedge clk);
    apbRead(8'h14, d); check("R7 soft sticky", d, 32'd1);
    apbWrite(8'h14, 32'h0); mdlSoft = 1'b0;
    checkAll("R7 soft cleared");

    // R8: fiq clear with data bit 0 low does nothing
    @(negedge clk); fiqSrc = 1'b1;
    apbWrite(8'h2C, 32'hFFFF_FFFE);
    checkAll("R8 fiq clr bit0 low");
    apbWrite(8'h2C, 32'h1); mdlFiqEn = 1'b0;
    checkAll("R8 fiq cleared");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] r;
      op = $urandom_range(0, 6);
      r = $urandom;
      case (op)
        0: begin apbWrite(8'h0C, r); mdlMask |= r; end
        1: begin apbWrite(8'h10, r); mdlMask &= ~r; end
        2: begin apbWrite(8'h14, r); mdlSoft = r[0]; end
        3: begin apbWrite(8'h28, r); if (r[0]) mdlFiqEn = 1'b1; end
        4: begin apbWrite(8'h2C, r); if (r[0]) mdlFiqEn = 1'b0; end
        5: begin @(negedge clk); irqSrc = r & $urandom; end
        default: begin @(negedge clk); fiqSrc = r[0]; end
      endcase
      checkAll("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule